// File: doc/BRIEF.md
# Pixel Run Fill and Copy Engine

This block moves short horizontal runs of pixels inside a byte-per-pixel frame store. Software programs it with 32-bit register writes. A write to an even word (address bit 2 clear) only stores an operand word. A write to an odd word (address bit 2 set) carries a command and starts a run. For that command the destination pixel index comes from the access address. The data word holds a source index and a run length. A source index of all ones turns the run into a solid fill with the stored operand. Any other source index gives a copy of consecutive pixels from source to destination.

The engine drives a synchronous memory port with separate read and write sides and moves one pixel per cycle. A copy uses a one-cycle pipeline: it reads in one cycle and writes in the next. When the deep colour input is high at the time a command is accepted, the run also writes the 32-bit direct colour plane. When the build also enables the control plane, the run writes that plane as well. A new command that arrives while a run is in flight is held off through the bus ready signal.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy, rd_en, wr_en, wr_deep_en and wr_ctl_en are low and bus_ready is high.
- R2: A write with bus_addr bit 2 clear is accepted at once, even during a run. It only stores bus_wdata as the operand. While idle it causes no memory read or write, and busy stays low.
- R3: A write with bus_addr bit 2 set starts a command. The destination index is bus_addr bits 22:3, so higher address bits are ignored. The source index is bus_wdata bits 23:0. The run length is bus_wdata bits 28:24 plus one (1 to 32). bus_wdata bits 31:29 are ignored.
- R4: A source index of 0xFFFFFF gives a fill. Pixel k of the run (k = 0 to length-1) writes wr_pix equal to operand bits 7:0 at destination+k. A fill makes no reads.
- R5: Any other source index gives a copy. In cycle k+1 after acceptance, rd_en is high with rd_addr = source+k. In cycle k+2, wr_en is high with wr_addr = destination+k and wr_pix = rd_pix. Memory returns the old contents when a read and a write hit the same address in the same cycle. Write addresses rise by one each cycle.
- R6: With deep mode, a fill writes {8'h00, operand bits 23:0} through wr_deep/wr_deep_en, and a copy writes rd_deep. Without deep mode, wr_deep_en stays low.
- R7: When CTL_PLANE is 1 and deep mode is set, wr_ctl_en follows wr_deep_en. A fill writes the same value as the deep plane, and a copy writes rd_ctl. wr_ctl_en is never high unless wr_deep_en is high.
- R8: Reads of the register window are always ready and return zero on bus_rdata.
- R9: While busy, a start write sees bus_ready low. It is accepted in the first cycle that busy is low and then runs as a normal command.
- R10: The operand is captured when a command is accepted. An operand write during a run does not change that run. It applies to later commands.
- R11: busy is high from the cycle after acceptance through the last write cycle, which is length+1 cycles in all.
- R12: Deep mode is sampled when a command is accepted. Changing deep_mode during a run does not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_mode | input | 1 | Also write the 32-bit colour plane (and control plane) |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address within the engine window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_rdata | output | 32 | Read data (always zero) |
| busy | output | 1 | A run is in flight |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 24 | Pixel index to read |
| rd_pix | input | 8 | Read byte-plane data, one cycle after rd_en |
| rd_deep | input | 32 | Read 32-bit plane data |
| rd_ctl | input | 32 | Read control plane data |
| wr_en | output | 1 | Byte-plane write strobe |
| wr_addr | output | 24 | Pixel index to write |
| wr_pix | output | 8 | Byte-plane write data |
| wr_deep_en | output | 1 | 32-bit plane write strobe |
| wr_deep | output | 32 | 32-bit plane write data |
| wr_ctl_en | output | 1 | Control plane write strobe |
| wr_ctl | output | 32 | Control plane write data |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an operand write and a run that is already using the previous operand. The second is a copy's read and an earlier write of the same run to the same pixel. The bench writes a new operand in the middle of a long fill and then queues a second start behind it. It expects the first run to keep the old byte and the second run to use the new one. For overlapping copies with destination one and two pixels above the source, a cycle model applies each write only to reads issued at least one cycle later. It compares every write beat, and the final memory contents, with that model.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int WORD_W    = 32;
    localparam int PIX_W     = 24;
    localparam int DST_W     = 20;
    localparam int DST_SHIFT = 3;
    localparam int SEL_BIT   = 2;
    localparam int LEN_W     = 5;
    localparam int LEN_LSB   = 24;
    localparam int PEL_W     = 8;
    localparam int DEEP_W    = 32;
    localparam int RGB_W     = 24;
    localparam logic [PIX_W-1:0] FILL_KEY = '1;

    typedef struct packed {
        logic              fill;
        logic              deep;
        logic [PIX_W-1:0]  src;
        logic [PIX_W-1:0]  dst;
        logic [LEN_W-1:0]  last;
        logic [WORD_W-1:0] opnd;
    } blit_cmd_t;

    typedef struct packed {
        logic              vld;
        logic              fill;
        logic              deep;
        logic [PIX_W-1:0]  dst;
        logic [WORD_W-1:0] opnd;
    } blit_beat_t;

    function automatic blit_cmd_t make_cmd(input logic [DST_W-1:0]  dst,
                                           input logic [WORD_W-1:0] data,
                                           input logic [WORD_W-1:0] opnd,
                                           input logic              deep);
        blit_cmd_t c;
        c.src  = data[PIX_W-1:0];
        c.fill = (data[PIX_W-1:0] == FILL_KEY);
        c.deep = deep;
        c.dst  = {{(PIX_W-DST_W){1'b0}}, dst};
        c.last = data[LEN_LSB+LEN_W-1:LEN_LSB];
        c.opnd = opnd;
        return c;
    endfunction
endpackage

// File: rtl/blit_bus_if.sv
module blit_bus_if
    import blit_pkg::*;
#(
    parameter int BUS_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_mode,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              busy,
    output logic              bus_ready,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              start,
    output blit_cmd_t         cmd
);
    logic [WORD_W-1:0] opnd_q;
    logic              is_start;
    logic              is_latch;
    logic              unused_bits;

    assign is_start  = bus_valid && bus_write && bus_addr[SEL_BIT];
    assign is_latch  = bus_valid && bus_write && !bus_addr[SEL_BIT];
    assign bus_ready = !(is_start && busy);
    assign start     = is_start && !busy;
    assign bus_rdata = '0;
    assign cmd       = make_cmd(bus_addr[DST_SHIFT+DST_W-1:DST_SHIFT], bus_wdata, opnd_q, deep_mode);
    assign unused_bits = ^{bus_addr, bus_wdata[WORD_W-1:LEN_LSB+LEN_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (is_latch) begin
            opnd_q <= bus_wdata;
        end
    end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  blit_cmd_t        cmd,
    output logic             active,
    output logic             rd_en,
    output logic [PIX_W-1:0] rd_addr,
    output blit_beat_t       beat
);
    blit_cmd_t        cmd_q;
    logic [LEN_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cmd_q  <= cmd;
            idx    <= '0;
            active <= 1'b1;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == cmd_q.last) begin
                active <= 1'b0;
            end
        end
    end

    assign rd_en     = active && !cmd_q.fill;
    assign rd_addr   = cmd_q.src + PIX_W'(idx);
    assign beat.vld  = active;
    assign beat.fill = cmd_q.fill;
    assign beat.deep = cmd_q.deep;
    assign beat.dst  = cmd_q.dst + PIX_W'(idx);
    assign beat.opnd = cmd_q.opnd;
endmodule

// File: rtl/blit_wr_stage.sv
module blit_wr_stage
    import blit_pkg::*;
#(
    parameter bit CTL_PLANE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  blit_beat_t        beat,
    input  logic [PEL_W-1:0]  rd_pix,
    input  logic [DEEP_W-1:0] rd_deep,
    input  logic [DEEP_W-1:0] rd_ctl,
    output logic              pend,
    output logic              wr_en,
    output logic [PIX_W-1:0]  wr_addr,
    output logic [PEL_W-1:0]  wr_pix,
    output logic              wr_deep_en,
    output logic [DEEP_W-1:0] wr_deep,
    output logic              wr_ctl_en,
    output logic [DEEP_W-1:0] wr_ctl
);
    blit_beat_t        s2;
    logic [DEEP_W-1:0] fill_word;
    logic              unused_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2 <= beat;
        end
    end

    assign fill_word  = {{(DEEP_W-RGB_W){1'b0}}, s2.opnd[RGB_W-1:0]};
    assign unused_op  = ^s2.opnd[WORD_W-1:RGB_W];
    assign pend       = s2.vld;
    assign wr_en      = s2.vld;
    assign wr_addr    = s2.dst;
    assign wr_pix     = s2.fill ? s2.opnd[PEL_W-1:0] : rd_pix;
    assign wr_deep_en = s2.vld && s2.deep;
    assign wr_deep    = s2.fill ? fill_word : rd_deep;

    generate
        if (CTL_PLANE) begin : g_ctl
            assign wr_ctl_en = s2.vld && s2.deep;
            assign wr_ctl    = s2.fill ? fill_word : rd_ctl;
        end else begin : g_no_ctl
            logic unused_ctl;
            assign unused_ctl = ^rd_ctl;
            assign wr_ctl_en  = 1'b0;
            assign wr_ctl     = '0;
        end
    endgenerate
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int BUS_AW    = 24,
    parameter bit CTL_PLANE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_mode,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              busy,
    output logic              rd_en,
    output logic [23:0]       rd_addr,
    input  logic [7:0]        rd_pix,
    input  logic [31:0]       rd_deep,
    input  logic [31:0]       rd_ctl,
    output logic              wr_en,
    output logic [23:0]       wr_addr,
    output logic [7:0]        wr_pix,
    output logic              wr_deep_en,
    output logic [31:0]       wr_deep,
    output logic              wr_ctl_en,
    output logic [31:0]       wr_ctl
);
    logic       start;
    logic       active;
    logic       pend;
    blit_cmd_t  cmd;
    blit_beat_t beat;

    assign busy = active || pend;

    blit_bus_if #(.BUS_AW(BUS_AW)) u_bus (
        .clk(clk), .rst(rst), .deep_mode(deep_mode),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .start(start), .cmd(cmd)
    );

    blit_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd),
        .active(active), .rd_en(rd_en), .rd_addr(rd_addr), .beat(beat)
    );

    blit_wr_stage #(.CTL_PLANE(CTL_PLANE)) u_wr (
        .clk(clk), .rst(rst), .beat(beat),
        .rd_pix(rd_pix), .rd_deep(rd_deep), .rd_ctl(rd_ctl),
        .pend(pend), .wr_en(wr_en), .wr_addr(wr_addr), .wr_pix(wr_pix),
        .wr_deep_en(wr_deep_en), .wr_deep(wr_deep),
        .wr_ctl_en(wr_ctl_en), .wr_ctl(wr_ctl)
    );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
    parameter int BUS_AW = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_ready,
    input logic              busy,
    input logic              rd_en,
    input logic              wr_en,
    input logic [23:0]       wr_addr,
    input logic              wr_deep_en,
    input logic              wr_ctl_en
);
    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr[2] && busy) |-> !bus_ready);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr[2] && bus_ready) |=> busy);

    // R2
    latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !bus_addr[2] && !busy) |=> !busy);

    // R5
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 24'd1));

    // R11
    wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |-> busy);

    // R6
    deep_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_deep_en);

    // R7
    ctl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctl_en |-> wr_deep_en);
endmodule

bind blit_engine blit_engine_chk #(.BUS_AW(BUS_AW)) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_ready(bus_ready), .busy(busy), .rd_en(rd_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_deep_en(wr_deep_en), .wr_ctl_en(wr_ctl_en)
);

// File: tb/blit_engine_tb_top.sv
module blit_engine_tb_top;
    localparam int MW = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        deep_mode = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, busy, rd_en, wr_en, wr_deep_en, wr_ctl_en;
    logic [31:0] bus_rdata, wr_deep, wr_ctl;
    logic [23:0] rd_addr, wr_addr;
    logic [7:0]  wr_pix;
    logic [7:0]  rd_pix = '0;
    logic [31:0] rd_deep = '0, rd_ctl = '0;

    always #10 clk = ~clk;

    blit_engine dut_i (
        .clk(clk), .rst(rst), .deep_mode(deep_mode),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_pix(rd_pix),
        .rd_deep(rd_deep), .rd_ctl(rd_ctl), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_pix(wr_pix), .wr_deep_en(wr_deep_en), .wr_deep(wr_deep),
        .wr_ctl_en(wr_ctl_en), .wr_ctl(wr_ctl)
    );

    // memory model and bench reference copies
    logic [7:0]  mp [MW];
    logic [31:0] md [MW];
    logic [31:0] mc [MW];
    logic [7:0]  rp [MW];
    logic [31:0] rdp[MW];
    logic [31:0] rcp[MW];

    always @(posedge clk) begin
        if (rd_en) begin
            rd_pix  <= mp[rd_addr[11:0]];
            rd_deep <= md[rd_addr[11:0]];
            rd_ctl  <= mc[rd_addr[11:0]];
        end
        if (wr_en)      mp[wr_addr[11:0]] <= wr_pix;
        if (wr_deep_en) md[wr_addr[11:0]] <= wr_deep;
        if (wr_ctl_en)  mc[wr_addr[11:0]] <= wr_ctl;
    end

    integer checks = 0, errors = 0;
    bit     mon_on = 0;
    logic [31:0] ref_op = '0;

    typedef struct {
        logic [124:0] v;
        string        tag;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [124:0] pack(input bit b, input bit re, input logic [23:0] ra,
                                          input bit we, input logic [23:0] wa, input logic [7:0] p,
                                          input bit de, input logic [31:0] dv, input bit ce,
                                          input logic [31:0] cv);
        return {b, re, re ? ra : 24'd0, we, we ? wa : 24'd0, we ? p : 8'd0,
                de, de ? dv : 32'd0, ce, ce ? cv : 32'd0};
    endfunction

    // per-cycle comparison of all memory-side outputs
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            logic [124:0] a;
            if (q.size() > 0) e = q.pop_front();
            else begin
                e.v = '0;
                e.tag = "R2 idle";
            end
            a = pack(busy, rd_en, rd_addr, wr_en, wr_addr, wr_pix,
                     wr_deep_en, wr_deep, wr_ctl_en, wr_ctl);
            chk(a == e.v, e.tag, {3'b0, a}, {3'b0, e.v});
        end
    end

    // reference: builds the expected beat stream and updates the reference memory
    task automatic model_run(input int dst, input int src, input int last, input bit deep,
                             input logic [31:0] op, input string tag);
        int L = last + 1;
        bit fill = (src == 24'hFFFFFF);
        logic [7:0]  pv[32];
        logic [31:0] dv[32];
        logic [31:0] cv[32];
        for (int k = 0; k < L; k++) begin
            if (fill) begin
                pv[k] = op[7:0];
                dv[k] = {8'h00, op[23:0]};
                cv[k] = {8'h00, op[23:0]};
                rp[(dst+k)%MW] = pv[k];
                if (deep) begin
                    rdp[(dst+k)%MW] = dv[k];
                    rcp[(dst+k)%MW] = cv[k];
                end
            end else begin
                if (k >= 2) begin
                    rp[(dst+k-2)%MW] = pv[k-2];
                    if (deep) begin
                        rdp[(dst+k-2)%MW] = dv[k-2];
                        rcp[(dst+k-2)%MW] = cv[k-2];
                    end
                end
                pv[k] = rp[(src+k)%MW];
                dv[k] = rdp[(src+k)%MW];
                cv[k] = rcp[(src+k)%MW];
            end
        end
        if (!fill) begin
            for (int k = (L >= 2 ? L-2 : 0); k < L; k++) begin
                rp[(dst+k)%MW] = pv[k];
                if (deep) begin
                    rdp[(dst+k)%MW] = dv[k];
                    rcp[(dst+k)%MW] = cv[k];
                end
            end
        end
        for (int c = 1; c <= L + 1; c++) begin
            exp_t e;
            bit re = !fill && (c <= L);
            bit we = (c >= 2);
            int w = c - 2;
            e.tag = tag;
            e.v = pack(1'b1, re, 24'(src + c - 1), we, 24'(dst + w),
                       we ? pv[w < 0 ? 0 : w] : 8'd0,
                       we && deep, we ? dv[w < 0 ? 0 : w] : 32'd0,
                       we && deep, we ? cv[w < 0 ? 0 : w] : 32'd0);
            q.push_back(e);
        end
    endtask

    task automatic op_write(input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 24'h000010; bus_wdata = d;
        #1;
        chk(bus_ready == 1'b1, tag, {127'd0, bus_ready}, 128'd1);
        @(posedge clk);
        #1;
        ref_op = d;
        bus_valid = 0;
    endtask

    task automatic go(input int dst, input int src, input int last, input logic [2:0] top,
                      input bit hi_addr, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 1;
        bus_addr  = {hi_addr, 23'(dst << 3)} | 24'd4;
        bus_wdata = {top, 5'(last), 24'(src)};
        #1;
        while (!bus_ready) begin
            chk(busy == 1'b1, "R9 held only while busy", {127'd0, busy}, 128'd1);
            @(negedge clk);
            #1;
        end
        model_run(dst, src, last, deep_mode, ref_op, tag);
        @(posedge clk);
        #1;
        bus_valid = 0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_probe(input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 24'h00000C;
        #1;
        chk(bus_ready == 1'b1 && bus_rdata == 32'd0, tag, {95'd0, bus_ready, bus_rdata}, {95'd0, 1'b1, 32'd0});
        @(posedge clk);
        #1;
        bus_valid = 0;
    endtask

    initial begin : main
        for (int i = 0; i < MW; i++) begin
            mp[i]  = 8'(i * 7 + 3);
            md[i]  = 32'(i * 32'h01010101 + 32'h11);
            mc[i]  = 32'(i * 32'h00030001 + 32'h5);
            rp[i]  = mp[i];
            rdp[i] = md[i];
            rcp[i] = mc[i];
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({busy, rd_en, wr_en, wr_deep_en, wr_ctl_en, bus_ready} == 6'b000001, "R1 reset",
            {122'd0, busy, rd_en, wr_en, wr_deep_en, wr_ctl_en, bus_ready}, 128'd1);
        mon_on = 1;

        // R2 operand latch only, R4 fill with ignored top bits (R3)
        op_write(32'hAABBCC5A, "R2 latch ready");
        repeat (3) @(negedge clk);
        go(100, 24'hFFFFFF, 7, 3'b111, 0, "R4 fill / R3 decode");
        drain();
        rd_probe("R8 idle read zero");

        // R5 long copy
        go(200, 10, 31, 3'b000, 0, "R5 copy 32");
        drain();

        // R6 R7 deep fill and copy
        deep_mode = 1;
        op_write(32'h00123456, "R2 latch");
        go(300, 24'hFFFFFF, 4, 3'b010, 0, "R6 R7 deep fill");
        drain();
        go(400, 300, 4, 3'b000, 0, "R6 R7 deep copy");
        drain();
        deep_mode = 0;

        // R5 overlapping copies: one and two pixels ahead
        go(501, 500, 7, 3'b000, 0, "R5 overlap +1");
        drain();
        go(602, 600, 7, 3'b000, 0, "R5 overlap +2");
        drain();

        // R10 operand change during a run, R9 held start, R8 read while busy
        op_write(32'h000000E1, "R2 latch");
        go(700, 24'hFFFFFF, 20, 3'b000, 0, "R10 first run old operand");
        op_write(32'h000000F2, "R10 latch accepted while busy");
        rd_probe("R8 read while busy");
        go(730, 24'hFFFFFF, 3, 3'b000, 0, "R9 R10 held run new operand");
        drain();

        // R12 deep mode sampled at acceptance
        deep_mode = 1;
        go(800, 40, 9, 3'b000, 0, "R12 deep sampled");
        repeat (3) @(negedge clk);
        deep_mode = 0;
        drain();

        // R3 address bits above the index ignored; R11 single-pixel run
        go(900, 24'hFFFFFF, 0, 3'b000, 1, "R3 high address / R11 len 1");
        drain();

        // final memory content
        for (int i = 0; i < MW; i++) begin
            if (mp[i] !== rp[i] || md[i] !== rdp[i] || mc[i] !== rcp[i])
                chk(1'b0, "R5 memory image", {56'd0, mp[i], md[i], mc[i]}, {56'd0, rp[i], rdp[i], rcp[i]});
        end
        chk(1'b1, "R5 memory image", 128'd0, 128'd0);
        mon_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule